// File: doc/BRIEF.md
# Occupancy-Tracked Learn Entry Writer

This block keeps a small table of 68-bit entries for one search device, along with a bank of comparand registers. The lowest bit of each entry says whether the slot is in use. The host can store any entry directly with a Write command. After a search reports a miss, the host can issue a Learn command. A Learn copies a chosen comparand into the first free slot of the table, or into the first free even/odd pair when the table is configured for 136-bit entries.

The table tracks its own free-slot pointer and full flag. Both are recomputed from the occupancy bits whenever a Write or a Learn lands, so the next command sees the updated state. Each accepted Learn also produces a one-cycle write strobe towards an external result SRAM. The address on that strobe is the slot the Learn filled.

A Learn is refused in four cases: no miss is pending, the table is full, the width setting is 272 bits, or the width setting is the unused code. A refused Learn writes nothing and produces a one-cycle error pulse instead of the SRAM strobe.

Top module: `ltw_learn_writer`

## Requirements
- R1: After reset every entry reads as zero, `free_ptr` is 0, `table_full` is 0, and `sram_we` and `learn_err` are 0.
- R2: A Write (`cmd_valid`=1, `cmd_op`=0) stores `cmd_data` at `cmd_addr`. Bit 0 of the stored data becomes the slot's occupancy (1 means used, 0 means free), so writing a zero in bit 0 frees the slot.
- R3: With `cfg_width`=00 (68-bit), `free_ptr` is the lowest index whose occupancy bit is 0. It reflects a Write or a Learn from the first cycle after the clock edge that stored it.
- R4: With `cfg_width`=01 (136-bit), `free_ptr` is the lowest even index i such that slots i and i+1 are both free.
- R5: `table_full` is 1 when no slot is free in 68-bit mode, or when no even-aligned free pair exists in 136-bit mode. It updates in the same cycle as `free_ptr`.
- R6: An accepted Learn in 68-bit mode stores the even register of the pair selected by `cmd_pair`, with bit 0 forced to 1, at `free_ptr`.
- R7: An accepted Learn in 136-bit mode stores the even register at `free_ptr` and the odd register at `free_ptr`+1. Both are stored with bit 0 forced to 1.
- R8: An accepted Learn raises `sram_we` for exactly the one cycle after the cycle in which the Learn was presented. During that cycle `sram_addr` holds the `free_ptr` value from the presentation cycle.
- R9: A Learn with no pending miss is refused. It writes nothing, produces no `sram_we`, and `learn_err` is 1 for the following cycle.
- R10: A Learn while `table_full` is 1 is refused in the same way as R9.
- R11: A Learn with `cfg_width`=10 (272-bit) or 11 is refused in the same way as R9. A refused Learn leaves the pending miss in place.
- R12: A search report with `srch_valid`=1 and `srch_hit`=0 sets the pending miss. A report with `srch_hit`=1 clears it. An accepted Learn consumes it. If a search report and an accepted Learn arrive in the same cycle, the search report decides the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 2 | Entry width: 00 = 68, 01 = 136, 10/11 = 272 (Learn refused) |
| srch_valid | input | 1 | Search status valid |
| srch_hit | input | 1 | Search result: 1 = hit, 0 = miss |
| cmp_we | input | 1 | Load one comparand register |
| cmp_pair | input | PW | Comparand pair being loaded |
| cmp_odd | input | 1 | 0 = even register, 1 = odd register of the pair |
| cmp_data | input | 68 | Comparand load data |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = Write, 1 = Learn |
| cmd_addr | input | AW | Write target slot |
| cmd_data | input | 68 | Write data |
| cmd_pair | input | PW | Comparand pair used by a Learn |
| rd_addr | input | AW | Table read address |
| rd_data | output | 68 | Entry at `rd_addr` (combinational) |
| free_ptr | output | AW | Next free slot or pair base |
| table_full | output | 1 | Table full for the current width |
| sram_we | output | 1 | External SRAM write strobe |
| sram_addr | output | AW | External SRAM write address |
| learn_err | output | 1 | One-cycle pulse for a refused Learn |

## Verification
The bench builds the block with DEPTH=8 and NUM_PAIRS=4, so both 68-bit and 136-bit fills reach `table_full` within a few commands. With eight slots, the bench can set up mixed patterns in which pairs are partly used, where the 68-bit pointer and the 136-bit pointer disagree. It can also refuse a Learn because the table is full in one width and then accept one in the other width. Four comparand pairs are enough to show that `cmd_pair` picks distinct even and odd data.

// File: rtl/ltw_pkg.sv
package ltw_pkg;
    localparam int ENTRY_W = 68;

    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic [1:0] {
        WM_X68  = 2'b00,
        WM_X136 = 2'b01,
        WM_X272 = 2'b10,
        WM_RSVD = 2'b11
    } width_mode_e;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_LEARN = 1'b1
    } cmd_op_e;

    // Force the occupancy bit of an entry to "used".
    function automatic entry_t mark_used(entry_t e);
        entry_t r;
        r = e;
        r[0] = 1'b1;
        return r;
    endfunction

    function automatic logic learn_width_ok(width_mode_e m);
        return (m == WM_X68) || (m == WM_X136);
    endfunction
endpackage

// File: rtl/ltw_cmp_bank.sv
module ltw_cmp_bank
    import ltw_pkg::*;
#(
    parameter int NUM_PAIRS = 16,
    localparam int PW = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_pair,
    input  logic          wr_odd,
    input  entry_t        wr_data,
    input  logic [PW-1:0] rd_pair,
    output entry_t        rd_even,
    output entry_t        rd_odd
);
    entry_t even_q [NUM_PAIRS];
    entry_t odd_q  [NUM_PAIRS];

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                even_q[p] <= '0;
                odd_q[p]  <= '0;
            end else if (wr_en && wr_pair == PW'(p)) begin
                if (wr_odd) odd_q[p]  <= wr_data;
                else        even_q[p] <= wr_data;
            end
        end
    end

    assign rd_even = even_q[rd_pair];
    assign rd_odd  = odd_q[rd_pair];
endmodule

// File: rtl/ltw_entry_store.sv
module ltw_entry_store
    import ltw_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_en,
    input  logic [AW-1:0]    a_addr,
    input  entry_t           a_data,
    input  logic             b_en,
    input  logic [AW-1:0]    b_addr,
    input  entry_t           b_data,
    input  logic [AW-1:0]    rd_addr,
    output entry_t           rd_data,
    output logic [DEPTH-1:0] occ
);
    entry_t slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                              slot_q[i] <= '0;
            else if (b_en && b_addr == AW'(i))    slot_q[i] <= b_data;
            else if (a_en && a_addr == AW'(i))    slot_q[i] <= a_data;
        end
        assign occ[i] = slot_q[i][0];
    end

    assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/ltw_free_finder.sv
module ltw_free_finder #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int NPAIR = DEPTH / 2
) (
    input  logic [DEPTH-1:0] occ,
    input  logic             pair_mode,
    output logic [AW-1:0]    ptr,
    output logic             full
);
    logic [NPAIR-1:0] pair_free;
    logic [AW-1:0]    one_idx, two_idx;
    logic             one_any, two_any;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pairs
        assign pair_free[k] = !occ[2*k] && !occ[2*k+1];
    end

    always_comb begin
        one_idx = '0;
        one_any = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                one_idx = AW'(i);
                one_any = 1'b1;
            end
        end
    end

    always_comb begin
        two_idx = '0;
        two_any = 1'b0;
        for (int k = NPAIR - 1; k >= 0; k--) begin
            if (pair_free[k]) begin
                two_idx = AW'(2 * k);
                two_any = 1'b1;
            end
        end
    end

    assign ptr  = pair_mode ? two_idx : one_idx;
    assign full = pair_mode ? !two_any : !one_any;
endmodule

// File: rtl/ltw_learn_writer.sv
module ltw_learn_writer
    import ltw_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int NUM_PAIRS = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_width,
    input  logic                srch_valid,
    input  logic                srch_hit,
    input  logic                cmp_we,
    input  logic [PW-1:0]       cmp_pair,
    input  logic                cmp_odd,
    input  logic [ENTRY_W-1:0]  cmp_data,
    input  logic                cmd_valid,
    input  logic                cmd_op,
    input  logic [AW-1:0]       cmd_addr,
    input  logic [ENTRY_W-1:0]  cmd_data,
    input  logic [PW-1:0]       cmd_pair,
    input  logic [AW-1:0]       rd_addr,
    output logic [ENTRY_W-1:0]  rd_data,
    output logic [AW-1:0]       free_ptr,
    output logic                table_full,
    output logic                sram_we,
    output logic [AW-1:0]       sram_addr,
    output logic                learn_err
);
    width_mode_e      mode;
    entry_t           src_even, src_odd;
    logic [DEPTH-1:0] occ;
    logic             miss_q, we_q, err_q;
    logic [AW-1:0]    addr_q;
    logic             is_write, is_learn, learn_ok, pair_mode;

    assign mode      = width_mode_e'(cfg_width);
    assign pair_mode = (mode == WM_X136);
    assign is_write  = cmd_valid && (cmd_op_e'(cmd_op) == OP_WRITE);
    assign is_learn  = cmd_valid && (cmd_op_e'(cmd_op) == OP_LEARN);
    assign learn_ok  = is_learn && learn_width_ok(mode) && !table_full && miss_q;

    ltw_cmp_bank #(.NUM_PAIRS(NUM_PAIRS)) u_cmp (
        .clk(clk), .rst(rst),
        .wr_en(cmp_we), .wr_pair(cmp_pair), .wr_odd(cmp_odd), .wr_data(cmp_data),
        .rd_pair(cmd_pair), .rd_even(src_even), .rd_odd(src_odd)
    );

    ltw_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .a_en(is_write || learn_ok),
        .a_addr(learn_ok ? free_ptr : cmd_addr),
        .a_data(learn_ok ? mark_used(src_even) : cmd_data),
        .b_en(learn_ok && pair_mode),
        .b_addr({free_ptr[AW-1:1], 1'b1}),
        .b_data(mark_used(src_odd)),
        .rd_addr(rd_addr), .rd_data(rd_data), .occ(occ)
    );

    ltw_free_finder #(.DEPTH(DEPTH)) u_find (
        .occ(occ), .pair_mode(pair_mode), .ptr(free_ptr), .full(table_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            miss_q <= 1'b0;
            we_q   <= 1'b0;
            err_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            if (srch_valid)    miss_q <= !srch_hit;
            else if (learn_ok) miss_q <= 1'b0;
            we_q  <= learn_ok;
            err_q <= is_learn && !learn_ok;
            if (learn_ok) addr_q <= free_ptr;
        end
    end

    assign sram_we   = we_q;
    assign sram_addr = addr_q;
    assign learn_err = err_q;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sram_we && !learn_err && free_ptr == '0 && !table_full));
    assert_ptr_slot_free_R3: assert property (@(posedge clk) disable iff (rst)
        (!pair_mode && !table_full) |-> !occ[free_ptr]);
    assert_ptr_pair_free_R4: assert property (@(posedge clk) disable iff (rst)
        (pair_mode && !table_full) |->
        (!free_ptr[0] && !occ[free_ptr] && !occ[{free_ptr[AW-1:1], 1'b1}]));
    assert_strobe_addr_R8: assert property (@(posedge clk) disable iff (rst)
        learn_ok |=> (sram_we && sram_addr == $past(free_ptr)));
    assert_no_miss_reject_R9: assert property (@(posedge clk) disable iff (rst)
        (is_learn && !miss_q) |=> (learn_err && !sram_we));
    assert_full_reject_R10: assert property (@(posedge clk) disable iff (rst)
        (is_learn && table_full) |=> (learn_err && !sram_we && $stable(occ)));
    assert_wide_reject_R11: assert property (@(posedge clk) disable iff (rst)
        (is_learn && cfg_width[1]) |=> (learn_err && !sram_we));
    assert_excl_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        !(sram_we && learn_err));
endmodule

// File: tb/sim_ltw_learn_writer.sv
module sim_ltw_learn_writer;
    localparam int DEPTH = 8;
    localparam int NP    = 4;
    localparam int AW    = 3;
    localparam int PW    = 2;

    typedef struct packed { logic ok; logic [AW-1:0] addr; } exp_t;

    logic clk = 0, rst = 1;
    logic [1:0] cfg_width = 2'b00;
    logic srch_valid = 0, srch_hit = 0;
    logic cmp_we = 0, cmp_odd = 0;
    logic [PW-1:0] cmp_pair = '0, cmd_pair = '0;
    logic [67:0] cmp_data = '0, cmd_data = '0, rd_data;
    logic cmd_valid = 0, cmd_op = 0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0, free_ptr, sram_addr;
    logic table_full, sram_we, learn_err;

    int checks = 0, fails = 0;
    bit done = 0;
    exp_t sb[$];

    logic [67:0] ent_m [DEPTH];
    logic [67:0] ev_m [NP];
    logic [67:0] od_m [NP];
    bit miss_m = 0;

    always #2 clk = ~clk;

    ltw_learn_writer #(.DEPTH(DEPTH), .NUM_PAIRS(NP)) u0 (
        .clk(clk), .rst(rst), .cfg_width(cfg_width),
        .srch_valid(srch_valid), .srch_hit(srch_hit),
        .cmp_we(cmp_we), .cmp_pair(cmp_pair), .cmp_odd(cmp_odd), .cmp_data(cmp_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_pair(cmd_pair), .rd_addr(rd_addr), .rd_data(rd_data),
        .free_ptr(free_ptr), .table_full(table_full),
        .sram_we(sram_we), .sram_addr(sram_addr), .learn_err(learn_err)
    );

    task automatic chk(input string req, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference pointer/full computed from the requirements.
    task automatic model_ptr(output logic [AW-1:0] p, output logic f);
        p = '0; f = 1;
        if (cfg_width == 2'b01) begin
            for (int k = DEPTH/2 - 1; k >= 0; k--)
                if (!ent_m[2*k][0] && !ent_m[2*k+1][0]) begin p = AW'(2*k); f = 0; end
        end else begin
            for (int i = DEPTH - 1; i >= 0; i--)
                if (!ent_m[i][0]) begin p = AW'(i); f = 0; end
        end
    endtask

    task automatic check_state(input string req);
        logic [AW-1:0] p; logic f;
        model_ptr(p, f);
        chk({req, " free_ptr"}, 68'(free_ptr), 68'(p));
        chk({req, " table_full"}, 68'(table_full), 68'(f));
    endtask

    task automatic check_entry(input string req, input int a);
        rd_addr = AW'(a);
        #1;
        chk($sformatf("%s entry%0d", req, a), rd_data, ent_m[a]);
    endtask

    task automatic load_cmp(input int p, input bit odd, input logic [67:0] d);
        @(negedge clk);
        cmp_we = 1; cmp_pair = PW'(p); cmp_odd = odd; cmp_data = d;
        @(posedge clk); @(negedge clk);
        cmp_we = 0;
        if (odd) od_m[p] = d; else ev_m[p] = d;
    endtask

    task automatic search(input bit hit);
        @(negedge clk);
        srch_valid = 1; srch_hit = hit;
        @(posedge clk); @(negedge clk);
        srch_valid = 0;
        miss_m = !hit;
    endtask

    task automatic do_write(input int a, input logic [67:0] d);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 0; cmd_addr = AW'(a); cmd_data = d;
        @(posedge clk); @(negedge clk);
        cmd_valid = 0;
        ent_m[a] = d;
    endtask

    // Driver: pushes the expected SRAM strobe or error pulse, then presents the Learn.
    task automatic do_learn(input int p);
        logic [AW-1:0] ptr; logic f; bit ok;
        exp_t e;
        model_ptr(ptr, f);
        ok = (cfg_width[1] == 1'b0) && !f && miss_m;
        e.ok = ok; e.addr = ok ? ptr : '0;
        sb.push_back(e);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 1; cmd_pair = PW'(p);
        @(posedge clk); @(negedge clk);
        cmd_valid = 0;
        if (ok) begin
            miss_m = 0;
            ent_m[ptr] = {ev_m[p][67:1], 1'b1};
            if (cfg_width == 2'b01) ent_m[ptr + 1] = {od_m[p][67:1], 1'b1};
        end
        @(negedge clk);
    endtask

    // Monitor: every strobe or error pulse must match the next queued item.
    always @(negedge clk) begin
        if (!rst && (sram_we || learn_err)) begin
            if (sb.size() == 0) begin
                chk("R9 unexpected pulse", {66'd0, sram_we, learn_err}, 68'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R8 strobe vs error", 68'(sram_we), 68'(e.ok));
                chk("R9 error pulse", 68'(learn_err), 68'(!e.ok));
                if (e.ok) chk("R8 sram_addr", 68'(sram_addr), 68'(e.addr));
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ent_m[i] = '0;
        for (int i = 0; i < NP; i++) begin ev_m[i] = '0; od_m[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 sram_we", 68'(sram_we), 68'd0);
        chk("R1 learn_err", 68'(learn_err), 68'd0);
        check_state("R1");
        check_entry("R1", 0);
        check_entry("R1", 7);

        for (int p = 0; p < NP; p++) begin
            load_cmp(p, 0, {4'(p), 64'hA5A5_0000_0000_1110} + 68'(p * 4));
            load_cmp(p, 1, {4'(p), 64'h5A5A_FFFF_0000_2220} + 68'(p * 4));
        end

        // R9: Learn with no pending miss
        do_learn(1);
        check_entry("R9", 0);
        check_state("R9");

        // R6, R8, R3: narrow Learn after a miss
        search(0);
        do_learn(1);
        check_entry("R6", 0);
        check_state("R3 after learn");

        // R12: miss consumed, then hit clears a fresh miss
        do_learn(2);
        check_entry("R12 consumed", 1);
        search(0);
        search(1);
        do_learn(2);
        check_entry("R12 hit cleared", 1);

        // R2, R3: writes set and clear occupancy
        do_write(1, 68'h0_1234_5678_9ABC_DEF1);
        do_write(2, 68'h0_0000_0000_0000_0FF0);
        do_write(3, 68'h0_3333_0000_0000_0001);
        check_entry("R2", 1);
        check_entry("R2", 2);
        check_state("R3 writes");
        do_write(0, 68'h0_0000_0000_0000_0000);
        check_state("R3 freed slot 0");
        do_write(0, 68'h0_0000_0000_0000_0101);

        // R4: pair mode, slot 2 free but pair (2,3) busy
        cfg_width = 2'b01;
        @(negedge clk);
        check_state("R4 pair pointer");

        // R7, R8: wide Learn fills 4 and 5
        search(0);
        do_learn(2);
        check_entry("R7 even", 4);
        check_entry("R7 odd", 5);
        check_state("R4 after wide learn");

        // R11: 272-bit setting refused, miss kept
        search(0);
        cfg_width = 2'b10;
        do_learn(3);
        check_entry("R11", 6);
        cfg_width = 2'b11;
        do_learn(3);
        check_entry("R11 reserved", 7);

        // Miss still pending: wide Learn fills 6,7 -> full
        cfg_width = 2'b01;
        do_learn(3);
        check_entry("R7 even", 6);
        check_entry("R7 odd", 7);
        check_state("R5 wide full");

        // R10: full in pair mode refuses
        search(0);
        do_learn(0);
        check_state("R10");

        // Narrow mode: slot 2 still free; miss still pending
        cfg_width = 2'b00;
        @(negedge clk);
        check_state("R5 narrow not full");
        do_learn(0);
        check_entry("R6 slot2", 2);
        check_state("R5 narrow full");
        search(0);
        do_learn(1);
        check_state("R10 narrow");
        for (int i = 0; i < DEPTH; i++) check_entry("R10 unchanged", i);

        repeat (3) @(negedge clk);
        chk("R8 scoreboard drained", 68'(sb.size()), 68'd0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule